// File: doc/BRIEF.md
# Gated Half-Period ADC Averager

This block drives a square-wave modulation clock toward an external radar front end that returns echo data for one of two carrier frequencies, chosen by the current clock level. The clock comes from the system clock through a programmable half-period divider; the nominal setting is 25 kHz. Eight signed 12-bit sample lines arrive together under one valid strobe. They form four quadrature channels, each with an I line and a Q line. At the start of each clock level a programmable settling window discards every sample while the external PLL recovers. The block then sums the next power-of-two number of valid samples per line and divides the sum by an arithmetic right shift.

Each level therefore gives one averaged value per line. Every clock period produces two data-cube entries: the low-level entry first, then the high-level entry. Each entry carries its level bit and its period index and goes into a show-ahead output FIFO. A start pulse begins a frame of 2048 periods. A completion flag rises with the final entry, and a sticky flag records any entry lost because the FIFO was full.

Top module: `halfper_avg`

## Requirements
- R1: After a start pulse taken while idle, `mod_clk` is low for `half_len` cycles, then high for `half_len` cycles, and this repeats for PERIODS (2048) periods. Outside a frame `mod_clk` is low.
- R2: Within a level, the cycle after the level edge has phase index 0, and the index counts up each cycle. A sample whose phase index is below `settle_len` is discarded. A sample presented on the cycle the level begins has index 0, so it is blanked whenever `settle_len` is at least 1.
- R3: After the settling window, only the first 2^`avg_log2` samples with `smp_valid` high are summed. Later samples in the same level, and any sample with `smp_valid` low, have no effect. `avg_log2` is taken at start and clamped to MAX_LOG2 (6).
- R4: Each averaged value is the signed sum arithmetically shifted right by `avg_log2`, keeping the low 12 bits. When fewer samples arrive, the shift is unchanged. When none arrive, the value is 0.
- R5: One entry is written at the clock edge that ends each level, and the low entry of a period comes before its high entry. The entry layout places line l at bits [12l+11:12l] (line 2k is I, line 2k+1 is Q of channel k), the level at bit 96 (1 = high) and the period index at bits [107:97].
- R6: The eight lines are averaged independently as two's-complement values, including full-scale -2048 and +2047 inputs.
- R7: The FIFO is show-ahead: `cube_word` holds the oldest entry while `cube_empty` is low, and `cube_rd` removes it at the next edge.
- R8: `frame_done` rises together with the write of entry 4095, which is the high entry of the last period. It stays high until the next start, and that start clears it.
- R9: If an entry is due while the FIFO is full, that entry is dropped and `overflow` becomes set and stays set. Entries already stored are kept. A start taken while idle clears the flag.
- R10: A start pulse during a running frame is ignored, and it does not change the timing, the period indices or the averages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a frame when idle; also latches the configuration |
| half_len | input | 16 | Level length in clock cycles (at least 1) |
| settle_len | input | 16 | Blanked cycles at the start of each level |
| avg_log2 | input | 3 | log2 of the number of samples averaged; values above 6 are clamped |
| smp_valid | input | 1 | Sample strobe for all lines |
| smp_data | input | 96 | Eight 12-bit two's-complement samples, line 0 in the low bits |
| mod_clk | output | 1 | Modulation clock to the front end |
| cube_rd | input | 1 | Pops the oldest FIFO entry |
| cube_empty | output | 1 | FIFO holds no entry |
| cube_word | output | 108 | Oldest FIFO entry |
| frame_done | output | 1 | Frame finished |
| overflow | output | 1 | Sticky: an entry was lost |

## Verification
The bench treats the cycle after the start edge as cycle 0. It drives the samples for cycle c at the falling edge inside cycle c and checks `mod_clk` at that same falling edge against level (c / half_len) mod 2. The entry for a level ending in cycle c is written at the rising edge that closes cycle c, so it appears on the FIFO outputs from the falling edge of cycle c+1. The same applies to `frame_done` and `overflow`: each is sampled at the first falling edge after the write that sets it. The bench reads the FIFO at falling edges against an independently computed list of entries, so an entry is never compared before its write edge has passed.

// File: rtl/hpavg_pkg.sv
package hpavg_pkg;
  typedef enum logic {LVL_LOW = 1'b0, LVL_HIGH = 1'b1} lvl_e;

  function automatic logic [7:0] clamp_u8(input logic [7:0] v, input logic [7:0] lim);
    return (v > lim) ? lim : v;
  endfunction
endpackage

// File: rtl/hpavg_clkgen.sv
module hpavg_clkgen
  import hpavg_pkg::*;
#(
  parameter int unsigned HL_W    = 16,
  parameter int unsigned PERIODS = 2048,
  parameter int unsigned PER_W   = $clog2(PERIODS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [HL_W-1:0]  half_len_i,
  output logic             run_o,
  output logic [HL_W-1:0]  phase_o,
  output logic             level_o,
  output logic [PER_W-1:0] period_o,
  output logic             lvl_end_o,
  output logic             frame_end_o
);
  logic             run_q, run_n;
  logic [HL_W-1:0]  phase_q, phase_n, hl_q, hl_n;
  lvl_e             lvl_q, lvl_n;
  logic [PER_W-1:0] per_q, per_n;
  logic             lvl_end, frame_end;

  always_comb begin
    run_n     = run_q;
    phase_n   = phase_q;
    lvl_n     = lvl_q;
    per_n     = per_q;
    hl_n      = hl_q;
    lvl_end   = run_q && (phase_q == hl_q - HL_W'(1));
    frame_end = lvl_end && (lvl_q == LVL_HIGH) && (per_q == PER_W'(PERIODS - 1));
    if (!run_q) begin
      if (start_i) begin
        run_n   = 1'b1;
        phase_n = '0;
        lvl_n   = LVL_LOW;
        per_n   = '0;
        hl_n    = half_len_i;
      end
    end else if (lvl_end) begin
      phase_n = '0;
      if (lvl_q == LVL_HIGH) begin
        lvl_n = LVL_LOW;
        if (frame_end) run_n = 1'b0;
        else           per_n = per_q + PER_W'(1);
      end else begin
        lvl_n = LVL_HIGH;
      end
    end else begin
      phase_n = phase_q + HL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      phase_q <= '0;
      lvl_q   <= LVL_LOW;
      per_q   <= '0;
      hl_q    <= '0;
    end else begin
      run_q   <= run_n;
      phase_q <= phase_n;
      lvl_q   <= lvl_n;
      per_q   <= per_n;
      hl_q    <= hl_n;
    end
  end

  assign run_o       = run_q;
  assign phase_o     = phase_q;
  assign level_o     = lvl_q;
  assign period_o    = per_q;
  assign lvl_end_o   = lvl_end;
  assign frame_end_o = frame_end;
endmodule

// File: rtl/hpavg_lane.sv
module hpavg_lane #(
  parameter int unsigned SMP_W = 12,
  parameter int unsigned ACC_W = 18,
  parameter int unsigned SH_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_i,
  input  logic             close_i,
  input  logic [SMP_W-1:0] smp_i,
  input  logic [SH_W-1:0]  shift_i,
  output logic [SMP_W-1:0] avg_o
);
  logic signed [ACC_W-1:0] acc_q, acc_n, acc_sum, addend, shifted;

  always_comb begin
    addend  = take_i ? {{(ACC_W-SMP_W){smp_i[SMP_W-1]}}, smp_i} : '0;
    acc_sum = acc_q + addend;
    shifted = acc_sum >>> shift_i;
    avg_o   = shifted[SMP_W-1:0];
    acc_n   = close_i ? '0 : acc_sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_n;
  end
endmodule

// File: rtl/hpavg_fifo.sv
module hpavg_fifo #(
  parameter int unsigned W     = 108,
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp_q, wp_n, rp_q, rp_n;
  logic         do_push, do_pop;

  always_comb begin
    empty_o = (wp_q == rp_q);
    full_o  = (wp_q[AW-1:0] == rp_q[AW-1:0]) && (wp_q[AW] != rp_q[AW]);
    do_push = push_i && !full_o;
    do_pop  = pop_i && !empty_o;
    wp_n    = do_push ? wp_q + (AW+1)'(1) : wp_q;
    rp_n    = do_pop  ? rp_q + (AW+1)'(1) : rp_q;
    dout_o  = mem[rp_q[AW-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_n;
      rp_q <= rp_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q[AW-1:0]] <= din_i;
  end
endmodule

// File: rtl/halfper_avg.sv
module halfper_avg
  import hpavg_pkg::*;
#(
  parameter int unsigned NLINES     = 8,
  parameter int unsigned SMP_W      = 12,
  parameter int unsigned MAX_LOG2   = 6,
  parameter int unsigned HL_W       = 16,
  parameter int unsigned PERIODS    = 2048,
  parameter int unsigned FIFO_DEPTH = 16,
  localparam int unsigned SH_W      = $clog2(MAX_LOG2 + 1),
  localparam int unsigned PER_W     = $clog2(PERIODS),
  localparam int unsigned WORD_W    = NLINES * SMP_W + 1 + PER_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [HL_W-1:0]         half_len,
  input  logic [HL_W-1:0]         settle_len,
  input  logic [SH_W-1:0]         avg_log2,
  input  logic                    smp_valid,
  input  logic [NLINES*SMP_W-1:0] smp_data,
  output logic                    mod_clk,
  input  logic                    cube_rd,
  output logic                    cube_empty,
  output logic [WORD_W-1:0]       cube_word,
  output logic                    frame_done,
  output logic                    overflow
);
  localparam int unsigned ACC_W = SMP_W + MAX_LOG2;
  localparam int unsigned CNT_W = MAX_LOG2 + 1;

  logic                    run, level, lvl_end, frame_end, cfg_load, take, fifo_full;
  logic [HL_W-1:0]         phase, settle_q, settle_n;
  logic [SH_W-1:0]         shift_q, shift_n, shift_clamped;
  logic [CNT_W-1:0]        used_q, used_n, limit;
  logic [PER_W-1:0]        period;
  logic [NLINES*SMP_W-1:0] avgs;
  logic [WORD_W-1:0]       entry;
  logic                    done_q, done_n, ovf_q, ovf_n;

  hpavg_clkgen #(.HL_W(HL_W), .PERIODS(PERIODS), .PER_W(PER_W)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .start_i(start), .half_len_i(half_len),
    .run_o(run), .phase_o(phase), .level_o(level), .period_o(period),
    .lvl_end_o(lvl_end), .frame_end_o(frame_end)
  );

  always_comb begin
    cfg_load      = start && !run;
    shift_clamped = SH_W'(clamp_u8(8'(avg_log2), 8'(MAX_LOG2)));
    settle_n      = cfg_load ? settle_len : settle_q;
    shift_n       = cfg_load ? shift_clamped : shift_q;
    limit         = CNT_W'(1) << shift_q;
    take          = run && smp_valid && (phase >= settle_q) && (used_q < limit);
    used_n        = lvl_end ? '0 : used_q + CNT_W'(take);
    done_n        = cfg_load ? 1'b0 : (done_q || frame_end);
    ovf_n         = cfg_load ? 1'b0 : (ovf_q || (lvl_end && fifo_full));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_q <= '0;
      shift_q  <= '0;
      used_q   <= '0;
      done_q   <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      settle_q <= settle_n;
      shift_q  <= shift_n;
      used_q   <= used_n;
      done_q   <= done_n;
      ovf_q    <= ovf_n;
    end
  end

  for (genvar l = 0; l < NLINES; l++) begin : g_lane
    hpavg_lane #(.SMP_W(SMP_W), .ACC_W(ACC_W), .SH_W(SH_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .take_i(take), .close_i(lvl_end),
      .smp_i(smp_data[l*SMP_W +: SMP_W]), .shift_i(shift_q),
      .avg_o(avgs[l*SMP_W +: SMP_W])
    );
  end

  assign entry = {period, level, avgs};

  hpavg_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_i(lvl_end), .din_i(entry),
    .pop_i(cube_rd), .dout_o(cube_word), .empty_o(cube_empty), .full_o(fifo_full)
  );

  assign mod_clk    = level;
  assign frame_done = done_q;
  assign overflow   = ovf_q;
endmodule

// File: rtl/hpavg_chk.sv
module hpavg_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic run,
  input logic mod_clk,
  input logic push,
  input logic fifo_full,
  input logic cube_empty,
  input logic frame_done,
  input logic overflow
);
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !mod_clk); // R1
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !run) |=> (run && !mod_clk)); // R1
  AST_TOGGLE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (mod_clk != $past(mod_clk))); // R5
  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cube_empty && !push) |=> cube_empty); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !run); // R8
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (push && fifo_full) |=> overflow); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !(start && !run)) |=> overflow); // R9
endmodule

bind halfper_avg hpavg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .run(run), .mod_clk(mod_clk),
  .push(lvl_end), .fifo_full(fifo_full), .cube_empty(cube_empty),
  .frame_done(frame_done), .overflow(overflow)
);

// File: tb/halfper_avg_tb.sv
`timescale 1ns/1ps
module halfper_avg_tb;
  localparam int NL = 8, SW = 12, HLW = 16, SHW = 3, PERIODS = 2048, WW = 108;
  localparam int NENT = 2 * PERIODS;
  // vector: half_len, settle_len, avg_log2, valid mode (0 all, 1 odd cycles), mid-run start
  localparam logic [39:0] VEC [4] = '{
    {8'd8, 8'd2, 8'd2, 8'd0, 8'd0},
    {8'd6, 8'd1, 8'd3, 8'd1, 8'd0},
    {8'd5, 8'd0, 8'd0, 8'd0, 8'd1},
    {8'd4, 8'd4, 8'd7, 8'd0, 8'd0}
  };

  logic clk = 1'b0, rst_n;
  logic start;
  logic [HLW-1:0] half_len, settle_len;
  logic [SHW-1:0] avg_log2;
  logic smp_valid;
  logic [NL*SW-1:0] smp_data;
  logic mod_clk, cube_rd, cube_empty, frame_done, overflow;
  logic [WW-1:0] cube_word;

  int n_tests = 0, n_fail = 0;
  logic [WW-1:0] exp_q [NENT];
  int wr_idx = 0, rd_idx = 0;
  bit rd_on = 0;

  always #2.5 clk = ~clk;

  halfper_avg u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .half_len(half_len),
    .settle_len(settle_len), .avg_log2(avg_log2), .smp_valid(smp_valid),
    .smp_data(smp_data), .mod_clk(mod_clk), .cube_rd(cube_rd),
    .cube_empty(cube_empty), .cube_word(cube_word),
    .frame_done(frame_done), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] smp_val(input int c, input int l);
    if (l == 0) return 12'h800;
    if (l == 7) return 12'h7FF;
    return 12'((c * 37 + l * 411 + (c >> 3) * 13) & 4095);
  endfunction

  // FIFO reader: compares every entry against the computed list (R2 R3 R4 R5 R6 R7)
  initial begin
    cube_rd = 1'b0;
    forever begin
      @(negedge clk);
      if (rd_on && !cube_empty) begin
        if (rd_idx < wr_idx)
          chk(cube_word === exp_q[rd_idx], "R2 R3 R4 R5 R6 R7 entry", cube_word, exp_q[rd_idx]);
        else
          chk(1'b0, "R5 unexpected entry", cube_word, '0);
        rd_idx++;
        cube_rd = 1'b1;
      end else begin
        cube_rd = 1'b0;
      end
    end
  end

  task automatic run_frame(input int hl, input int st, input int lg, input int vm,
                           input bit reading, input bit mid_start, input bit ovf_probe);
    int lgc, ncyc;
    int acc [NL];
    int used;
    lgc = (lg > 6) ? 6 : lg;
    ncyc = 2 * hl * PERIODS;
    wr_idx = 0; rd_idx = 0; rd_on = reading; used = 0;
    for (int l = 0; l < NL; l++) acc[l] = 0;
    @(negedge clk);
    half_len = 16'(hl); settle_len = 16'(st); avg_log2 = 3'(lg); start = 1'b1;
    for (int c = 0; c < ncyc; c++) begin
      int ph, lv, per;
      bit vld;
      @(negedge clk);
      start = (mid_start && c == 100) ? 1'b1 : 1'b0; // R10: ignored while running
      ph = c % hl; lv = (c / hl) % 2; per = c / (2 * hl);
      if (c == 0) chk(frame_done == 1'b0, "R8 cleared by start", 108'(frame_done), 108'(0));
      if (mod_clk !== lv[0]) chk(1'b0, "R1 mod_clk level", 108'(mod_clk), 108'(lv));
      if (ovf_probe && c == 16 * hl) chk(overflow == 1'b0, "R9 no overflow at full", 108'(overflow), 108'(0));
      if (ovf_probe && c == 17 * hl) chk(overflow == 1'b1, "R9 overflow set", 108'(overflow), 108'(1));
      vld = (vm == 0) ? 1'b1 : c[0];
      smp_valid = vld;
      for (int l = 0; l < NL; l++) smp_data[l*SW +: SW] = smp_val(c, l);
      if (ph == 0) begin
        used = 0;
        for (int l = 0; l < NL; l++) acc[l] = 0;
      end
      if (vld && ph >= st && used < (1 << lgc)) begin
        for (int l = 0; l < NL; l++) acc[l] += int'($signed(smp_val(c, l)));
        used++;
      end
      if (ph == hl - 1) begin
        logic [WW-1:0] w;
        for (int l = 0; l < NL; l++) begin
          int a;
          a = acc[l] >>> lgc;
          w[l*SW +: SW] = a[SW-1:0];
        end
        w[96] = lv[0];
        w[107:97] = per[10:0];
        if (wr_idx < NENT) exp_q[wr_idx] = w;
        wr_idx++;
      end
    end
    @(negedge clk);
    smp_valid = 1'b0;
    chk(frame_done == 1'b1, "R8 done after last entry", 108'(frame_done), 108'(1));
    chk(mod_clk == 1'b0, "R1 idle low after frame", 108'(mod_clk), 108'(0));
    chk(wr_idx == NENT, "R8 entry count", 108'(wr_idx), 108'(NENT));
    if (reading) begin
      for (int k = 0; k < 50 && rd_idx < wr_idx; k++) @(negedge clk);
      chk(rd_idx == NENT, "R7 all entries read", 108'(rd_idx), 108'(NENT));
      @(negedge clk);
      chk(cube_empty == 1'b1, "R7 empty after drain", 108'(cube_empty), 108'(1));
      chk(overflow == 1'b0, "R9 no overflow while drained", 108'(overflow), 108'(0));
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; half_len = '0; settle_len = '0; avg_log2 = '0;
    smp_valid = 1'b0; smp_data = '0;
    repeat (3) @(negedge clk);
    chk(mod_clk == 1'b0, "R1 reset mod_clk", 108'(mod_clk), 108'(0));
    chk(cube_empty == 1'b1, "R7 reset empty", 108'(cube_empty), 108'(1));
    chk(frame_done == 1'b0, "R8 reset done", 108'(frame_done), 108'(0));
    chk(overflow == 1'b0, "R9 reset overflow", 108'(overflow), 108'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(mod_clk == 1'b0, "R1 idle before start", 108'(mod_clk), 108'(0));

    for (int v = 0; v < 4; v++) begin
      run_frame(int'(VEC[v][39:32]), int'(VEC[v][31:24]), int'(VEC[v][23:16]),
                int'(VEC[v][15:8]), 1'b1, VEC[v][0], 1'b0);
    end

    // Directed: FIFO overflow with no reader (R9)
    run_frame(4, 1, 1, 0, 1'b0, 1'b0, 1'b1);
    chk(overflow == 1'b1, "R9 overflow sticky at end", 108'(overflow), 108'(1));
    rd_on = 1'b1; rd_idx = 0;
    for (int k = 0; k < 40; k++) @(negedge clk);
    chk(rd_idx == 16, "R9 only stored entries remain", 108'(rd_idx), 108'(16));
    chk(cube_empty == 1'b1, "R9 dropped entries absent", 108'(cube_empty), 108'(1));
    rd_on = 1'b0;

    // Directed: start clears sticky flag (R9)
    @(negedge clk);
    half_len = 16'd4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(overflow == 1'b0, "R9 cleared by start", 108'(overflow), 108'(0));
    chk(mod_clk == 1'b0, "R1 first level low", 108'(mod_clk), 108'(0));

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule